// File: doc/BRIEF.md
# Per-Page DMA Permission Guard

This block sits in the path of every device DMA request and decides, one request at a time, whether the access may go on to memory. It translates nothing. A request carries a device identifier and a physical address. The block resolves the device to a protection domain through a small table that software programs. It then reads that domain's bit vector at the 4 KB page number of the address. A set bit lets the request through. A clear bit, an unmapped device or a page beyond the table blocks it. The address leaves the block unchanged, together with the allow or block verdict.

Requests arrive on a valid/ready stream, and verdicts leave on a second valid/ready stream through a single output register. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the verdict is held and no new request is taken.

Plain control pins let software set or clear single permission bits and bind or unbind devices. The first blocked request is latched into a sticky fault record, and a clear pulse releases it. At full size the table needs one bit for each page in each domain, so 1 Mbit covers a 4 GB space. The default parameters keep the table small.

Top module: `dma_page_guard`

## Requirements
- R1: After reset, `rsp_valid` and `fault` are low, `req_ready` is high, every device is unbound and every permission bit is clear, so any request is blocked.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_allow`, `rsp_dev` and `rsp_addr` hold steady and no request is taken.
- R3: The verdict for a request taken at one clock edge is presented on `rsp_valid` from the next edge.
- R4: `rsp_addr` and `rsp_dev` equal the address and device of the request they answer.
- R5: The page number is `req_addr >> 12`. `rsp_allow` is 1 exactly when the device is bound, the page number is below `NUM_PAGES`, and the bit for that page in the bound domain's vector is 1.
- R6: A request from a device that is not bound to a domain is always blocked.
- R7: A request whose page number is `NUM_PAGES` or above is blocked, whatever bits are set.
- R8: Each domain has its own vector. A bit set for one domain grants nothing to another, and devices bound to the same domain get identical verdicts.
- R9: `bit_we` writes `bit_val` into the bit at (`bit_dom`, `bit_page`) at the clock edge. A request taken at that same edge is judged with the old value, and later requests see the new one.
- R10: A blocked request sets `fault` and records its device, domain (0 if the device is unbound) and address. While `fault` is high, later blocks leave the record unchanged. `fault_clr` drops `fault` at the next edge, unless a blocked request is taken at that same edge, in which case that request is recorded.
- R11: `map_we` with `map_en`=1 binds `map_dev` to `map_dom`. With `map_en`=0 it unbinds the device. The change applies to requests taken after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_dev | input | DEV_W | Requesting device identifier |
| req_addr | input | ADDR_W | Physical address of the access |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Downstream takes the verdict |
| rsp_allow | output | 1 | 1 = forward the access, 0 = block it |
| rsp_dev | output | DEV_W | Device of the judged request |
| rsp_addr | output | ADDR_W | Unchanged address of the judged request |
| bit_we | input | 1 | Permission bit write strobe |
| bit_dom | input | DOM_W | Domain of the bit to write |
| bit_page | input | PG_W | Page index of the bit to write |
| bit_val | input | 1 | Value written (1 = grant) |
| map_we | input | 1 | Device binding write strobe |
| map_dev | input | DEV_W | Device to bind or unbind |
| map_dom | input | DOM_W | Domain the device is bound to |
| map_en | input | 1 | 1 = bind, 0 = unbind |
| fault_clr | input | 1 | Clears the sticky fault record |
| fault | output | 1 | Sticky flag: a request was blocked |
| fault_dev | output | DEV_W | Device of the recorded block |
| fault_dom | output | DOM_W | Domain of the recorded block |
| fault_addr | output | ADDR_W | Address of the recorded block |

## Verification
The hardest cases to reach are those where two things land on the same clock edge: a permission write or a fault clear, and a request taken at that edge. The bench lines these up by driving both on the same falling edge, so the table and the fault record must show whether the old or the new state was used. Back-pressure is handled the same way. A verdict is held with `rsp_ready` low while a second request waits, and the bench checks that the first verdict stays unchanged and the second request stays queued. Apart from these cases, the bench sweeps every device against every page and two pages beyond the table, and compares each verdict with a pattern computed in the bench.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic [1:0] {
    VERD_GRANT = 2'd0,
    VERD_UNBOUND = 2'd1,
    VERD_RANGE = 2'd2,
    VERD_DENY = 2'd3
  } verdict_e;
endpackage

// File: rtl/dpg_dev_map.sv
module dpg_dev_map #(
  parameter int NUM_DEVS = 8,
  parameter int DEV_W = 3,
  parameter int DOM_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DEV_W-1:0] wr_dev,
  input  logic [DOM_W-1:0] wr_dom,
  input  logic             wr_bind,
  input  logic [DEV_W-1:0] rd_dev,
  output logic             rd_hit,
  output logic [DOM_W-1:0] rd_dom
);
  logic [NUM_DEVS-1:0]            bound;
  logic [NUM_DEVS-1:0][DOM_W-1:0] dom_of;

  for (genvar g = 0; g < NUM_DEVS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bound[g]  <= 1'b0;
        dom_of[g] <= '0;
      end else if (wr_en && (wr_dev == DEV_W'(g))) begin
        bound[g]  <= wr_bind;
        dom_of[g] <= wr_dom;
      end
    end
  end

  always_comb begin
    rd_hit = 1'b0;
    rd_dom = '0;
    if (32'(rd_dev) < NUM_DEVS) begin
      rd_hit = bound[rd_dev];
      rd_dom = dom_of[rd_dev];
    end
  end
endmodule

// File: rtl/dpg_perm_bits.sv
module dpg_perm_bits #(
  parameter int NUM_DOMAINS = 4,
  parameter int NUM_PAGES = 32,
  parameter int DOM_W = 2,
  parameter int PG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DOM_W-1:0] wr_dom,
  input  logic [PG_W-1:0]  wr_page,
  input  logic             wr_val,
  input  logic [DOM_W-1:0] rd_dom,
  input  logic [PG_W-1:0]  rd_page,
  output logic             rd_bit
);
  logic [NUM_DOMAINS-1:0][NUM_PAGES-1:0] vec;

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec[d] <= '0;
      end else if (wr_en && (wr_dom == DOM_W'(d)) && (32'(wr_page) < NUM_PAGES)) begin
        vec[d][wr_page] <= wr_val;
      end
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    if ((32'(rd_dom) < NUM_DOMAINS) && (32'(rd_page) < NUM_PAGES))
      rd_bit = vec[rd_dom][rd_page];
  end
endmodule

// File: rtl/dpg_fault_rec.sv
module dpg_fault_rec #(
  parameter int DEV_W = 3,
  parameter int DOM_W = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [DEV_W-1:0]  set_dev,
  input  logic [DOM_W-1:0]  set_dom,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr,
  output logic              flag,
  output logic [DEV_W-1:0]  rec_dev,
  output logic [DOM_W-1:0]  rec_dom,
  output logic [ADDR_W-1:0] rec_addr
);
  logic take;
  assign take = set && (!flag || clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      rec_dev  <= '0;
      rec_dom  <= '0;
      rec_addr <= '0;
    end else begin
      if (take) begin
        flag     <= 1'b1;
        rec_dev  <= set_dev;
        rec_dom  <= set_dom;
        rec_addr <= set_addr;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  // R10: record is sticky while not cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag && $stable(rec_addr) && $stable(rec_dev));
  // R10: clear without a new block drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !flag);
endmodule

// File: rtl/dma_page_guard.sv
module dma_page_guard #(
  parameter int NUM_DOMAINS = 4,
  parameter int NUM_PAGES = 32,
  parameter int NUM_DEVS = 8,
  parameter int ADDR_W = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int DOM_W = (NUM_DOMAINS > 1) ? $clog2(NUM_DOMAINS) : 1,
  parameter int DEV_W = (NUM_DEVS > 1) ? $clog2(NUM_DEVS) : 1,
  parameter int PG_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic [DEV_W-1:0]  rsp_dev,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              bit_we,
  input  logic [DOM_W-1:0]  bit_dom,
  input  logic [PG_W-1:0]   bit_page,
  input  logic              bit_val,
  input  logic              map_we,
  input  logic [DEV_W-1:0]  map_dev,
  input  logic [DOM_W-1:0]  map_dom,
  input  logic              map_en,
  input  logic              fault_clr,
  output logic              fault,
  output logic [DEV_W-1:0]  fault_dev,
  output logic [DOM_W-1:0]  fault_dom,
  output logic [ADDR_W-1:0] fault_addr
);
  import dpg_pkg::*;

  localparam int UP_W = ADDR_W - PAGE_SHIFT;
  localparam logic [UP_W-1:0] PAGE_LIMIT = UP_W'(NUM_PAGES);

  logic             req_fire;
  logic [UP_W-1:0]  upage;
  logic             in_range;
  logic             map_hit;
  logic [DOM_W-1:0] map_dom_rd;
  logic             perm_bit;
  verdict_e         verdict;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign upage     = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign in_range  = upage < PAGE_LIMIT;

  dpg_dev_map #(.NUM_DEVS(NUM_DEVS), .DEV_W(DEV_W), .DOM_W(DOM_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .wr_en(map_we), .wr_dev(map_dev), .wr_dom(map_dom), .wr_bind(map_en),
    .rd_dev(req_dev), .rd_hit(map_hit), .rd_dom(map_dom_rd)
  );

  dpg_perm_bits #(.NUM_DOMAINS(NUM_DOMAINS), .NUM_PAGES(NUM_PAGES),
                  .DOM_W(DOM_W), .PG_W(PG_W)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bit_we), .wr_dom(bit_dom), .wr_page(bit_page), .wr_val(bit_val),
    .rd_dom(map_dom_rd), .rd_page(upage[PG_W-1:0]), .rd_bit(perm_bit)
  );

  always_comb begin
    if (!map_hit)       verdict = VERD_UNBOUND;
    else if (!in_range) verdict = VERD_RANGE;
    else if (!perm_bit) verdict = VERD_DENY;
    else                verdict = VERD_GRANT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_dev   <= '0;
      rsp_addr  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_allow <= (verdict == VERD_GRANT);
      rsp_dev   <= req_dev;
      rsp_addr  <= req_addr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  dpg_fault_rec #(.DEV_W(DEV_W), .DOM_W(DOM_W), .ADDR_W(ADDR_W)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .set(req_fire && (verdict != VERD_GRANT)),
    .set_dev(req_dev), .set_dom(map_hit ? map_dom_rd : '0), .set_addr(req_addr),
    .clr(fault_clr),
    .flag(fault), .rec_dev(fault_dev), .rec_dom(fault_dom), .rec_addr(fault_addr)
  );

  // R2: verdict held under back-pressure
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_allow) && $stable(rsp_addr) && $stable(rsp_dev));
  // R3: one cycle from acceptance to verdict
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);
  // R6: unbound device never allowed
  a_r6_unbound: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !map_hit |=> !rsp_allow);
  // R7: page beyond table never allowed
  a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !in_range |=> !rsp_allow);
  // R10: a block always leaves a fault raised
  a_r10_raise: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && (verdict != VERD_GRANT) |=> fault);
endmodule

// File: tb/test_dma_page_guard.sv
module test_dma_page_guard;
  localparam int ND = 4, NP = 32, NV = 8, AW = 32;
  localparam int DMW = 2, DVW = 3, PGW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 1;
  logic [DVW-1:0] req_dev = '0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_allow, fault;
  logic [DVW-1:0] rsp_dev, fault_dev;
  logic [AW-1:0] rsp_addr, fault_addr;
  logic [DMW-1:0] fault_dom;
  logic bit_we = 0, bit_val = 0, map_we = 0, map_en = 0, fault_clr = 0;
  logic [DMW-1:0] bit_dom = '0, map_dom = '0;
  logic [PGW-1:0] bit_page = '0;
  logic [DVW-1:0] map_dev = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_page_guard #(.NUM_DOMAINS(ND), .NUM_PAGES(NP), .NUM_DEVS(NV), .ADDR_W(AW)) i_dma_page_guard (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_dev(req_dev), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_allow(rsp_allow),
    .rsp_dev(rsp_dev), .rsp_addr(rsp_addr),
    .bit_we(bit_we), .bit_dom(bit_dom), .bit_page(bit_page), .bit_val(bit_val),
    .map_we(map_we), .map_dev(map_dev), .map_dom(map_dom), .map_en(map_en),
    .fault_clr(fault_clr), .fault(fault), .fault_dev(fault_dev),
    .fault_dom(fault_dom), .fault_addr(fault_addr)
  );

  function automatic bit pat(int d, int p);
    return ((p * 3 + d * 7) % 5) < 2;
  endfunction

  function automatic bit expect_allow(int dev, int page);
    if (dev >= 6) return 0;
    if (page >= NP) return 0;
    return pat(dev % ND, page);
  endfunction

  function automatic logic [AW-1:0] mk_addr(int page);
    return AW'((page << 12) | ((page * 37 + 5) & 12'hfff));
  endfunction

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr_bit(input int d, input int p, input bit v);
    bit_we = 1; bit_dom = DMW'(d); bit_page = PGW'(p); bit_val = v;
    @(negedge clk);
    bit_we = 0;
  endtask

  task automatic wr_map(input int dv, input int dm, input bit en);
    map_we = 1; map_dev = DVW'(dv); map_dom = DMW'(dm); map_en = en;
    @(negedge clk);
    map_we = 0;
  endtask

  // drive at a falling edge, response visible at the next falling edge
  task automatic send(input int dv, input logic [AW-1:0] a);
    req_valid = 1; req_dev = DVW'(dv); req_addr = a;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_chk(input int dv, input int page, input bit exp_allow, input string rq);
    logic [AW-1:0] a;
    a = mk_addr(page);
    send(dv, a);
    check({rq, " valid"}, rsp_valid, 1);
    check({rq, " allow"}, rsp_allow, exp_allow);
    check("R4 addr", rsp_addr, a);
    check("R4 dev", rsp_dev, dv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 req_ready", req_ready, 1);
    check("R1 fault", fault, 0);
    send_chk(0, 0, 0, "R1 blocked");

    // program table and bindings
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < NP; p++) wr_bit(d, p, pat(d, p));
    for (int v = 0; v < 6; v++) wr_map(v, v % ND, 1);

    // R5/R6/R7/R8 sweep: all devices, all pages plus two beyond the table
    for (int v = 0; v < NV; v++)
      for (int p = 0; p < NP + 2; p++)
        send_chk(v, p, expect_allow(v, p),
                 (v >= 6) ? "R6" : (p >= NP) ? "R7" : "R5_R8");

    // R8: a bit granted only in domain 0 gives nothing to domain 1
    wr_bit(0, 2, 1); wr_bit(1, 2, 0);
    send_chk(0, 2, 1, "R8 own dom");
    send_chk(1, 2, 0, "R8 other dom");
    send_chk(5, 2, 0, "R8 shared dom");

    // R9: write and request on the same edge -> old value, then new
    wr_bit(1, 3, 0);
    bit_we = 1; bit_dom = 1; bit_page = 3; bit_val = 1;
    send(1, mk_addr(3));
    bit_we = 0;
    check("R9 same edge old", rsp_allow, 0);
    send_chk(1, 3, 1, "R9 after write");
    wr_bit(1, 3, 0);
    send_chk(1, 3, 0, "R9 cleared");

    // R11 unbind and rebind
    wr_map(0, 0, 0);
    send_chk(0, 2, 0, "R11 unbound");
    wr_map(0, 0, 1);
    send_chk(0, 2, 1, "R11 rebound");

    // R10 fault record
    fault_clr = 1; @(negedge clk); fault_clr = 0;
    check("R10 cleared", fault, 0);
    send(7, mk_addr(4));
    check("R10 raised", fault, 1);
    check("R10 dev", fault_dev, 7);
    check("R10 dom unbound", fault_dom, 0);
    check("R10 addr", fault_addr, mk_addr(4));
    send(1, mk_addr(3));
    check("R10 sticky addr", fault_addr, mk_addr(4));
    check("R10 sticky dev", fault_dev, 7);
    fault_clr = 1;
    send(1, mk_addr(3));
    fault_clr = 0;
    check("R10 clr+block flag", fault, 1);
    check("R10 clr+block addr", fault_addr, mk_addr(3));
    check("R10 clr+block dom", fault_dom, 1);
    fault_clr = 1;
    send(0, mk_addr(2));
    fault_clr = 0;
    check("R10 clr+grant", fault, 0);

    // R2/R3 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    send(0, mk_addr(2));
    check("R3 valid", rsp_valid, 1);
    check("R2 ready low", req_ready, 0);
    req_valid = 1; req_dev = 1; req_addr = mk_addr(3);
    @(negedge clk);
    check("R2 hold allow", rsp_allow, 1);
    check("R2 hold addr", rsp_addr, mk_addr(2));
    @(negedge clk);
    check("R2 hold dev", rsp_dev, 0);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R2 next valid", rsp_valid, 1);
    check("R2 next addr", rsp_addr, mk_addr(3));
    check("R2 next allow", rsp_allow, 0);
    @(negedge clk);
    check("R2 drained", rsp_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule